// File: doc/BRIEF.md
# I2C Read-Only Target with Clock Stretching

This block is a 7-bit-address I2C target that serves only master read requests. It watches the bus through synchronizers, recognizes Start and Stop, and collects the address byte. When the address matches the static own-address input and the direction bit requests a read, the target acknowledges. It then pulls SCL low and holds it there until local logic has written a byte and asked for the clock to be released.

The byte goes out most significant bit first. After the eighth bit the target lets go of SDA so that the master can answer. An acknowledge from the master starts another hold-and-send round, and a not-acknowledge sends the block back to idle until the next Start. Local logic sees three indications. A buffer-full flag shows whether a byte is waiting. A sticky per-byte interrupt flag is set at the end of every byte and cleared by a strobe. A direction status bit is set after a matched read address.

Both bus lines are open-drain. Each has a sampled input and an output enable, and an asserted enable pulls the line low.

Top module: `i2c_rd_target`

## Requirements
- R1: Out of reset, scl_oe, sda_oe, buf_full, irq_flag and rw_stat are all 0.
- R2: A Start (SDA falling while SCL is high) at any point, including a repeated Start in the middle of a data byte, releases both lines and restarts address reception. A Stop (SDA rising while SCL is high) returns the block to idle. Both clear rw_stat.
- R3: The address byte is sent with bits [7:1] as the address, MSB first, and bit [0] as direction, where 1 means read. If bits [7:1] equal own_addr and bit [0] is 1, the target pulls SDA low for the ninth clock and sets rw_stat.
- R4: On an address mismatch, or on a write request (bit [0] = 0), the target drives neither line and raises no flag until the next Start.
- R5: After the acknowledged address, the target holds SCL low until it is released.
- R6: A pulse on txd_wr stores txd and sets buf_full. A pulse on rel_req releases SCL only while buf_full is 1; with buf_full at 0 it is ignored and SCL stays low.
- R7: The stored byte is sent MSB first. SDA changes only while SCL is low.
- R8: buf_full clears on the eighth falling SCL edge of a data byte.
- R9: After the eighth falling SCL edge of a data byte, SDA is released for the master's answer.
- R10: irq_flag is set on the ninth falling SCL edge of every byte, address or data. It stays set until an irq_clr pulse, and it is not set before that edge.
- R11: If the master answers NACK (SDA high on the ninth clock), the target stops holding SCL, drives nothing more and ignores further clocks until the next Start.
- R12: If the master answers ACK (SDA low on the ninth clock), SCL is held low again until the next load and release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr | input | 7 | Static target address |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| txd_wr | input | 1 | Write strobe for the transmit byte |
| txd | input | 8 | Transmit byte |
| rel_req | input | 1 | Clock-release request strobe |
| irq_clr | input | 1 | Clears irq_flag |
| buf_full | output | 1 | A transmit byte is waiting |
| irq_flag | output | 1 | Sticky end-of-byte flag |
| rw_stat | output | 1 | A read address matched in this transfer |

## Verification
The bench first releases the clock with an empty buffer. A design that honoured that request would let SCL rise and send stale data. It then checks buf_full and irq_flag right after the eighth and the ninth SCL falls. A flag tied to the wrong edge shows up as a wrong value at one of those two points. A repeated Start is issued while a byte is half sent; a design that missed it would keep shifting and would not acknowledge the fresh address. Mismatched and write-direction addresses are sent and extra clocks follow a NACK, so that any stray acknowledge, stretch or flag becomes visible on the lines.

// File: rtl/i2c_rt_pkg.sv
package i2c_rt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_HOLD,
    ST_LAUNCH,
    ST_SHIFT,
    ST_MACK
  } rt_state_e;
endpackage

// File: rtl/i2c_rt_sync.sv
module i2c_rt_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_i,
  output logic [LINES-1:0] line_s
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], line_i[g]};
    end

    // idle bus level is high, so the chain resets to ones
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= chain_d;
    end

    assign line_s[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_rt_evt.sv
module i2c_rt_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_d_q;
  logic sda_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d_q <= 1'b1;
      sda_d_q <= 1'b1;
    end else begin
      scl_d_q <= scl_s;
      sda_d_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise = scl_s & ~scl_d_q;
    scl_fall = ~scl_s & scl_d_q;
    // SCL must be high in both samples so a simultaneous change is not taken
    start_ev = scl_s & scl_d_q & sda_d_q & ~sda_s;
    stop_ev  = scl_s & scl_d_q & ~sda_d_q & sda_s;
  end
endmodule

// File: rtl/i2c_rt_txbuf.sv
module i2c_rt_txbuf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              full_clr,
  output logic [DATA_W-1:0] buf_data,
  output logic              full
);
  logic [DATA_W-1:0] data_q;
  logic              full_q;
  logic              full_d;

  always_comb begin
    // a write in the same cycle as the clear keeps the buffer full
    if (wr_en)         full_d = 1'b1;
    else if (full_clr) full_d = 1'b0;
    else               full_d = full_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_q <= '0;
    else if (wr_en) data_q <= wr_data;
  end

  assign buf_data = data_q;
  assign full     = full_q;
endmodule

// File: rtl/i2c_rt_fsm.sv
module i2c_rt_fsm
  import i2c_rt_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = DATA_W - 1,
  localparam int unsigned CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_s,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              buf_full,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              rel_req,
  input  logic              irq_clr,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              bf_clr,
  output logic              irq_flag,
  output logic              rw_stat,
  output rt_state_e         state
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(DATA_W);

  rt_state_e         state_q, state_d;
  logic [CNT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              sda_oe_q, sda_oe_d;
  logic              scl_oe_q, scl_oe_d;
  logic              irq_q, irq_d;
  logic              rw_q, rw_d;
  logic              ack_q, ack_d;
  logic              irq_set;
  logic              addr_hit;

  assign addr_hit = (sh_q[DATA_W-1:1] == own_addr) && sh_q[0];

  always_comb begin
    state_d  = state_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    sda_oe_d = sda_oe_q;
    scl_oe_d = scl_oe_q;
    rw_d     = rw_q;
    ack_d    = ack_q;
    irq_set  = 1'b0;
    bf_clr   = 1'b0;

    if (start_ev) begin
      state_d  = ST_ADDR;
      bit_d    = '0;
      sda_oe_d = 1'b0;
      scl_oe_d = 1'b0;
      rw_d     = 1'b0;
    end else if (stop_ev) begin
      state_d  = ST_IDLE;
      sda_oe_d = 1'b0;
      scl_oe_d = 1'b0;
      rw_d     = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[DATA_W-2:0], sda_s};
            bit_d = bit_q + 1'b1;
          end else if (scl_fall && bit_q == ALL_BITS) begin
            if (addr_hit) begin
              sda_oe_d = 1'b1;
              rw_d     = 1'b1;
              state_d  = ST_AACK;
            end else begin
              state_d  = ST_IDLE;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            sda_oe_d = 1'b0;
            scl_oe_d = 1'b1;
            irq_set  = 1'b1;
            state_d  = ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (rel_req && buf_full) begin
            sh_d     = buf_data;
            sda_oe_d = ~buf_data[DATA_W-1];
            bit_d    = '0;
            state_d  = ST_LAUNCH;
          end
        end
        ST_LAUNCH: begin
          // first bit settles on SDA one cycle before SCL is let go
          scl_oe_d = 1'b0;
          state_d  = ST_SHIFT;
        end
        ST_SHIFT: begin
          if (scl_fall) begin
            if (bit_q == LAST_BIT) begin
              sda_oe_d = 1'b0;
              bf_clr   = 1'b1;
              state_d  = ST_MACK;
            end else begin
              bit_d    = bit_q + 1'b1;
              sh_d     = {sh_q[DATA_W-2:0], 1'b0};
              sda_oe_d = ~sh_q[DATA_W-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            ack_d = ~sda_s;
          end else if (scl_fall) begin
            irq_set = 1'b1;
            if (ack_q) begin
              scl_oe_d = 1'b1;
              state_d  = ST_HOLD;
            end else begin
              state_d  = ST_IDLE;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end

    if (irq_set)      irq_d = 1'b1;
    else if (irq_clr) irq_d = 1'b0;
    else              irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bit_q    <= '0;
      sh_q     <= '0;
      sda_oe_q <= 1'b0;
      scl_oe_q <= 1'b0;
      irq_q    <= 1'b0;
      rw_q     <= 1'b0;
      ack_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      bit_q    <= bit_d;
      sh_q     <= sh_d;
      sda_oe_q <= sda_oe_d;
      scl_oe_q <= scl_oe_d;
      irq_q    <= irq_d;
      rw_q     <= rw_d;
      ack_q    <= ack_d;
    end
  end

  assign scl_oe   = scl_oe_q;
  assign sda_oe   = sda_oe_q;
  assign irq_flag = irq_q;
  assign rw_stat  = rw_q;
  assign state    = state_q;
endmodule

// File: rtl/i2c_rd_target.sv
module i2c_rd_target
  import i2c_rt_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W     = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              txd_wr,
  input  logic [DATA_W-1:0] txd,
  input  logic              rel_req,
  input  logic              irq_clr,
  output logic              buf_full,
  output logic              irq_flag,
  output logic              rw_stat
);
  logic [1:0]        lines_s;
  logic              scl_rise, scl_fall, start_ev, stop_ev;
  logic              bf_clr;
  logic [DATA_W-1:0] buf_data;
  rt_state_e         fsm_state;

  i2c_rt_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i ({scl_i, sda_i}),
    .line_s (lines_s)
  );

  i2c_rt_evt u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (lines_s[1]),
    .sda_s    (lines_s[0]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2c_rt_txbuf #(.DATA_W(DATA_W)) u_txbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (txd_wr),
    .wr_data  (txd),
    .full_clr (bf_clr),
    .buf_data (buf_data),
    .full     (buf_full)
  );

  i2c_rt_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .sda_s    (lines_s[0]),
    .own_addr (own_addr),
    .buf_full (buf_full),
    .buf_data (buf_data),
    .rel_req  (rel_req),
    .irq_clr  (irq_clr),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .bf_clr   (bf_clr),
    .irq_flag (irq_flag),
    .rw_stat  (rw_stat),
    .state    (fsm_state)
  );
endmodule

// File: rtl/i2c_rd_target_chk.sv
module i2c_rd_target_chk
  import i2c_rt_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      scl_i,
  input logic      scl_oe,
  input logic      sda_oe,
  input logic      txd_wr,
  input logic      buf_full,
  input logic      irq_flag,
  input logic      irq_clr,
  input rt_state_e state
);
  p_sda_moves_scl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  p_release_needs_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> $past(buf_full));

  p_write_sets_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(txd_wr) |-> buf_full);

  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_flag) && !$past(irq_clr)) |-> irq_flag);

  p_stretch_in_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> (state == ST_HOLD || state == ST_LAUNCH));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (!sda_oe && !scl_oe));
endmodule

bind i2c_rd_target i2c_rd_target_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_i    (scl_i),
  .scl_oe   (scl_oe),
  .sda_oe   (sda_oe),
  .txd_wr   (txd_wr),
  .buf_full (buf_full),
  .irq_flag (irq_flag),
  .irq_clr  (irq_clr),
  .state    (fsm_state)
);

// File: tb/i2c_rd_target_bench.sv
module i2c_rd_target_bench;
  localparam int HALF = 20;
  localparam logic [6:0] OWN = 7'h5A;

  logic       clk;
  logic       rst_n;
  logic       m_scl, m_sda;
  logic       scl_oe, sda_oe;
  logic       txd_wr, rel_req, irq_clr;
  logic [7:0] txd;
  logic       buf_full, irq_flag, rw_stat;
  logic       scl_line, sda_line;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [7:0] exp_q[$];

  assign scl_line = m_scl & ~scl_oe;
  assign sda_line = m_sda & ~sda_oe;

  i2c_rd_target u_i2c_rd_target (
    .clk      (clk),
    .rst_n    (rst_n),
    .own_addr (OWN),
    .scl_i    (scl_line),
    .sda_i    (sda_line),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .txd_wr   (txd_wr),
    .txd      (txd),
    .rel_req  (rel_req),
    .irq_clr  (irq_clr),
    .buf_full (buf_full),
    .irq_flag (irq_flag),
    .rw_stat  (rw_stat)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic clock_bit(input logic b, output logic r);
    m_sda = b;
    wclk(HALF);
    m_scl = 1'b1;
    wait_scl_high();
    wclk(HALF);
    r = sda_line;
    m_scl = 1'b0;
    wclk(HALF);
  endtask

  task automatic m_start();
    m_sda = 1'b1;
    wclk(HALF);
    m_scl = 1'b1;
    wait_scl_high();
    wclk(HALF);
    m_sda = 1'b0;
    wclk(HALF);
    m_scl = 1'b0;
    wclk(HALF);
  endtask

  task automatic m_stop();
    m_sda = 1'b0;
    wclk(HALF);
    m_scl = 1'b1;
    wait_scl_high();
    wclk(HALF);
    m_sda = 1'b1;
    wclk(HALF);
  endtask

  task automatic send_addr(input logic [6:0] a, input logic rw, output logic acked);
    logic r;
    for (int i = 6; i >= 0; i--) clock_bit(a[i], r);
    clock_bit(rw, r);
    chk("R10 irq low before ninth fall", irq_flag, 1'b0);
    clock_bit(1'b1, r);
    acked = ~r;
  endtask

  task automatic pulse_wr(input logic [7:0] b);
    txd = b;
    txd_wr = 1'b1;
    wclk(1);
    txd_wr = 1'b0;
    wclk(2);
    exp_q.push_back(b);
  endtask

  task automatic pulse_rel();
    rel_req = 1'b1;
    wclk(1);
    rel_req = 1'b0;
    wclk(2);
  endtask

  task automatic pulse_clr();
    irq_clr = 1'b1;
    wclk(1);
    irq_clr = 1'b0;
    wclk(2);
  endtask

  // master lets go of SCL; local side serves the stretched clock
  task automatic serve(input logic [7:0] b, input bit try_empty);
    m_sda = 1'b1;
    wclk(2);
    m_scl = 1'b1;
    wclk(30);
    chk("R5 SCL held low while stretching", scl_line, 1'b0);
    if (try_empty) begin
      chk("R8 buffer empty before load", buf_full, 1'b0);
      pulse_rel();
      wclk(10);
      chk("R6 release with empty buffer ignored", scl_line, 1'b0);
    end
    pulse_clr();
    chk("R10 irq cleared by strobe", irq_flag, 1'b0);
    pulse_wr(b);
    chk("R6 write sets buf_full", buf_full, 1'b1);
    wclk(10);
    chk("R6 SCL still low before release", scl_line, 1'b0);
    pulse_rel();
  endtask

  task automatic read_byte(input logic ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, r);
      d[i] = r;
    end
    chk("R8 buf_full clear after eighth fall", buf_full, 1'b0);
    chk("R9 SDA released after eighth fall", sda_oe, 1'b0);
    chk("R10 irq low after eighth fall", irq_flag, 1'b0);
    clock_bit(~ack, r);
    chk("R10 irq set on ninth fall", irq_flag, 1'b1);
    if (ack) chk("R12 stretch after master ACK", scl_oe, 1'b1);
    else     chk("R11 no stretch after master NACK", scl_oe, 1'b0);
  endtask

  task automatic check_byte(input logic [7:0] d);
    logic [7:0] e;
    e = exp_q.pop_front();
    chk("R7 byte sent MSB first", d, e);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic       ack, r;
    logic [7:0] d;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    txd_wr = 1'b0; rel_req = 1'b0; irq_clr = 1'b0; txd = '0;
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    // R1 reset state
    chk("R1 scl_oe", scl_oe, 1'b0);
    chk("R1 sda_oe", sda_oe, 1'b0);
    chk("R1 buf_full", buf_full, 1'b0);
    chk("R1 irq_flag", irq_flag, 1'b0);
    chk("R1 rw_stat", rw_stat, 1'b0);

    // two-byte read: ACK then NACK
    m_start();
    send_addr(OWN, 1'b1, ack);
    chk("R3 address ACK", ack, 1'b1);
    chk("R3 rw_stat set", rw_stat, 1'b1);
    chk("R10 irq after address byte", irq_flag, 1'b1);
    chk("R5 stretch after address", scl_oe, 1'b1);
    serve(8'hA5, 1'b1);
    read_byte(1'b1, d);
    check_byte(d);
    serve(8'h3C, 1'b0);
    read_byte(1'b0, d);
    check_byte(d);
    pulse_clr();
    for (int k = 0; k < 3; k++) begin
      clock_bit(1'b1, r);
      chk("R11 bus ignored after NACK", r, 1'b1);
    end
    chk("R11 no irq after NACK", irq_flag, 1'b0);
    m_stop();
    chk("R2 stop clears rw_stat", rw_stat, 1'b0);

    // mismatched address
    m_start();
    send_addr(OWN ^ 7'h01, 1'b1, ack);
    chk("R4 no ACK on mismatch", ack, 1'b0);
    chk("R4 no stretch on mismatch", scl_oe, 1'b0);
    chk("R4 no irq on mismatch", irq_flag, 1'b0);
    for (int k = 0; k < 9; k++) begin
      clock_bit(1'b1, r);
      chk("R4 line untouched after mismatch", r, 1'b1);
    end
    m_stop();

    // write request to own address
    m_start();
    send_addr(OWN, 1'b0, ack);
    chk("R4 no ACK on write request", ack, 1'b0);
    chk("R4 rw_stat stays clear", rw_stat, 1'b0);
    chk("R4 no irq on write request", irq_flag, 1'b0);
    m_stop();

    // repeated Start in the middle of a data byte
    m_start();
    send_addr(OWN, 1'b1, ack);
    chk("R3 address ACK before abort", ack, 1'b1);
    serve(8'hA5, 1'b0);
    clock_bit(1'b1, r);
    chk("R7 first bit of aborted byte", r, 1'b1);
    clock_bit(1'b1, r);
    chk("R7 second bit of aborted byte", r, 1'b0);
    void'(exp_q.pop_front());
    m_start();
    chk("R2 repeated start releases SDA", sda_oe, 1'b0);
    chk("R2 repeated start releases SCL", scl_oe, 1'b0);
    chk("R2 repeated start clears rw_stat", rw_stat, 1'b0);
    pulse_clr();
    send_addr(OWN, 1'b1, ack);
    chk("R2 address accepted after repeated start", ack, 1'b1);
    serve(8'h96, 1'b0);
    read_byte(1'b0, d);
    check_byte(d);
    m_stop();
    wclk(20);

    done = 1;
    finish_run();
  end
endmodule